// File: doc/BRIEF.md
# Bi-Endian Load Data Aligner

This block sits between a 32-bit memory read port and a register write port. For each load it receives the returned memory word, the low bits of the byte address, the access size, a signed flag and an endian-mode bit. It extracts the addressed bytes, puts them in significance order for the selected mode and widens the value to 32 bits with zeros or with copies of its sign bit. Loads whose address does not suit their size are flagged and produce no register write.

Each request carries its own mode bit. Software can therefore switch between big-endian and little-endian ordering from one load to the next with no flush or idle cycle. The result is registered and appears on the cycle after the request, so the register file sees a clean flop output. An asynchronous active-low reset is synchronised inside the block before it reaches the output registers.

Top module: `ld_align_unit`

## Requirements
- R1: After reset and before the first request, `wr_valid_o` and `misalign_o` are 0 and `wr_data_o` is 0.
- R2: Byte lane k of `mem_data_i` (bits 8k+7 down to 8k) holds the byte whose address has low bits k. A byte load (`size_i` = 00) returns the lane chosen by `byte_ofs_i` in either mode, zero-extended when `signed_i` is 0.
- R3: A byte load with `signed_i` = 1 fills bits 31..8 with bit 7 of the selected byte.
- R4: A halfword load (`size_i` = 01) at even offset o returns lane o as bits 15..8 and lane o+1 as bits 7..0 when `big_endian_i` = 1. With `big_endian_i` = 0 the lanes swap places.
- R5: A halfword load fills bits 31..16 with zeros when `signed_i` = 0, or with bit 15 of the ordered value when `signed_i` = 1.
- R6: A word load (`size_i` = 10, and also 11) at offset 0 returns lane 0 as the most significant byte in big-endian mode. In little-endian mode it returns `mem_data_i` unchanged.
- R7: A halfword at an odd offset, or a word at a nonzero offset, sets `misalign_o` = 1 and `wr_valid_o` = 0 on the next cycle and leaves `wr_data_o` unchanged.
- R8: The result of a request sampled at a clock edge appears on the following edge. A cycle with `req_valid_i` = 0 yields `wr_valid_o` = 0 and `misalign_o` = 0 on the next cycle.
- R9: The mode bit is sampled with each request, so back-to-back requests in opposite modes each follow their own mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Memory data and attributes are valid this cycle |
| byte_ofs_i | input | 2 | Low bits of the byte address |
| size_i | input | 2 | 00 byte, 01 halfword, 10/11 word |
| signed_i | input | 1 | 1 selects sign extension |
| big_endian_i | input | 1 | 1 selects big-endian ordering |
| mem_data_i | input | 32 | Word returned by memory |
| wr_valid_o | output | 1 | Register write strobe |
| wr_data_o | output | 32 | Aligned and extended load value |
| misalign_o | output | 1 | Offset does not suit the access size |

## Verification
Directed loads place 0x80-style bytes in every lane. This separates zero extension from sign extension and exposes a wrong lane pick at each offset. Halfword and word loads use words with distinct bytes (for example 0x11223344) in both modes, so a swapped or mirrored ordering gives a different value. All illegal offsets are tried for halfwords and words, each followed by a legal load, which shows that the held data and the flag clear correctly. Random back-to-back loads with a random mode bit on every request test mode switching and repeated requests against a bench model.

// File: rtl/ld_align_pkg.sv
package ld_align_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_WIDE = 2'b11
  } acc_size_e;
endpackage

// File: rtl/ld_rst_sync.sv
module ld_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_n = sync_q;
endmodule

// File: rtl/ld_lane_pick.sv
// Gathers the addressed bytes into least-significant-first order.
module ld_lane_pick #(
  parameter int LANES = 4,
  parameter int OFS_W = 2
) (
  input  logic [LANES*8-1:0] mem_data,
  input  logic [OFS_W-1:0]   ofs,
  input  logic [OFS_W-1:0]   nb_m1,
  input  logic               big_endian,
  output logic [LANES*8-1:0] picked
);
  for (genvar j = 0; j < LANES; j++) begin : g_pos
    logic [OFS_W-1:0] src;
    always_comb begin
      if (big_endian) src = ofs + nb_m1 - OFS_W'(j);
      else            src = ofs + OFS_W'(j);
    end
    assign picked[j*8 +: 8] = mem_data[src*8 +: 8];
  end
endmodule

// File: rtl/ld_extend.sv
// Keeps the bytes of the access and fills the rest with zero or sign.
module ld_extend #(
  parameter int LANES = 4,
  parameter int OFS_W = 2
) (
  input  logic [LANES*8-1:0] picked,
  input  logic [OFS_W-1:0]   nb_m1,
  input  logic               sext,
  output logic [LANES*8-1:0] result
);
  logic sign_bit;
  logic fill;

  always_comb begin
    sign_bit = picked[nb_m1*8 + 7];
    fill     = sext & sign_bit;
  end

  for (genvar j = 0; j < LANES; j++) begin : g_byte
    always_comb begin
      if (OFS_W'(j) <= nb_m1) result[j*8 +: 8] = picked[j*8 +: 8];
      else                    result[j*8 +: 8] = {8{fill}};
    end
  end
endmodule

// File: rtl/ld_misalign_chk.sv
// An access of 2^k bytes must have its low k offset bits clear.
module ld_misalign_chk #(
  parameter int OFS_W = 2
) (
  input  logic [OFS_W-1:0] ofs,
  input  logic [OFS_W-1:0] nb_m1,
  output logic             misaligned
);
  always_comb misaligned = |(ofs & nb_m1);
endmodule

// File: rtl/ld_align_unit.sv
module ld_align_unit #(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int OFS_W = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid_i,
  input  logic [OFS_W-1:0]  byte_ofs_i,
  input  logic [1:0]        size_i,
  input  logic              signed_i,
  input  logic              big_endian_i,
  input  logic [DATA_W-1:0] mem_data_i,
  output logic              wr_valid_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              misalign_o
);
  import ld_align_pkg::*;

  logic              rst_sync_n;
  logic [OFS_W-1:0]  nb_m1;
  logic [DATA_W-1:0] picked;
  logic [DATA_W-1:0] extended;
  logic              mis_comb;

  logic              valid_d, valid_q;
  logic              mis_d, mis_q;
  logic              data_en;
  logic [DATA_W-1:0] data_d, data_q;

  ld_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb begin
    case (acc_size_e'(size_i))
      SZ_BYTE: nb_m1 = '0;
      SZ_HALF: nb_m1 = OFS_W'(1);
      default: nb_m1 = OFS_W'(LANES - 1);
    endcase
  end

  ld_lane_pick #(.LANES(LANES), .OFS_W(OFS_W)) u_pick (
    .mem_data   (mem_data_i),
    .ofs        (byte_ofs_i),
    .nb_m1      (nb_m1),
    .big_endian (big_endian_i),
    .picked     (picked)
  );

  ld_extend #(.LANES(LANES), .OFS_W(OFS_W)) u_ext (
    .picked (picked),
    .nb_m1  (nb_m1),
    .sext   (signed_i),
    .result (extended)
  );

  ld_misalign_chk #(.OFS_W(OFS_W)) u_mis (
    .ofs        (byte_ofs_i),
    .nb_m1      (nb_m1),
    .misaligned (mis_comb)
  );

  always_comb begin
    valid_d = req_valid_i & ~mis_comb;
    mis_d   = req_valid_i &  mis_comb;
    data_en = valid_d;
    data_d  = extended;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      valid_q <= 1'b0;
      mis_q   <= 1'b0;
    end else begin
      valid_q <= valid_d;
      mis_q   <= mis_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      data_q <= '0;
    end else if (data_en) begin
      data_q <= data_d;
    end
  end

  assign wr_valid_o = valid_q;
  assign misalign_o = mis_q;
  assign wr_data_o  = data_q;
endmodule

// File: rtl/ld_align_unit_chk.sv
module ld_align_unit_chk #(
  parameter int DATA_W = 32,
  parameter int OFS_W  = 2
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              req_valid_i,
  input logic [OFS_W-1:0]  byte_ofs_i,
  input logic [1:0]        size_i,
  input logic              signed_i,
  input logic              big_endian_i,
  input logic [DATA_W-1:0] mem_data_i,
  input logic              wr_valid_o,
  input logic [DATA_W-1:0] wr_data_o,
  input logic              misalign_o
);
  AST_NEVER_BOTH: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(wr_valid_o && misalign_o)); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !req_valid_i |=> (!wr_valid_o && !misalign_o)); // R8

  AST_WORD_OFFSET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid_i && size_i[1] && byte_ofs_i != '0) |=> misalign_o); // R7

  AST_HOLD_ON_MIS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    misalign_o |-> $stable(wr_data_o)); // R7

  AST_UBYTE_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid_i && size_i == 2'b00 && !signed_i) |=>
      (wr_valid_o && wr_data_o[DATA_W-1:8] == '0)); // R2

  AST_SHALF_FILL: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid_i && size_i == 2'b01 && signed_i && !byte_ofs_i[0]) |=>
      ($countones(wr_data_o[DATA_W-1:15]) == 0 ||
       $countones(wr_data_o[DATA_W-1:15]) == DATA_W - 15)); // R5

  AST_WORD_LE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid_i && size_i[1] && !big_endian_i && byte_ofs_i == '0) |=>
      (wr_data_o == $past(mem_data_i))); // R6

  AST_WORD_BE_TOP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid_i && size_i[1] && big_endian_i && byte_ofs_i == '0) |=>
      (wr_data_o[DATA_W-1 -: 8] == $past(mem_data_i[7:0]))); // R6
endmodule

bind ld_align_unit ld_align_unit_chk #(.DATA_W(DATA_W), .OFS_W(OFS_W)) chk_i (
  .clk          (clk),
  .rst_sync_n   (rst_sync_n),
  .req_valid_i  (req_valid_i),
  .byte_ofs_i   (byte_ofs_i),
  .size_i       (size_i),
  .signed_i     (signed_i),
  .big_endian_i (big_endian_i),
  .mem_data_i   (mem_data_i),
  .wr_valid_o   (wr_valid_o),
  .wr_data_o    (wr_data_o),
  .misalign_o   (misalign_o)
);

// File: tb/ld_align_unit_tb_top.sv
`timescale 1ns/1ps
module ld_align_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid_i;
  logic [1:0]  byte_ofs_i;
  logic [1:0]  size_i;
  logic        signed_i;
  logic        big_endian_i;
  logic [31:0] mem_data_i;
  logic        wr_valid_o;
  logic [31:0] wr_data_o;
  logic        misalign_o;

  int checks = 0;
  int errors = 0;
  logic [31:0] last_good = 32'h0;

  always #2.5 clk = ~clk;

  ld_align_unit dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid_i  (req_valid_i),
    .byte_ofs_i   (byte_ofs_i),
    .size_i       (size_i),
    .signed_i     (signed_i),
    .big_endian_i (big_endian_i),
    .mem_data_i   (mem_data_i),
    .wr_valid_o   (wr_valid_o),
    .wr_data_o    (wr_data_o),
    .misalign_o   (misalign_o)
  );

  function automatic logic [7:0] lane(input logic [31:0] d, input int k);
    return d[k*8 +: 8];
  endfunction

  // returns {misaligned, value}
  function automatic logic [32:0] model(input logic [31:0] d, input logic [1:0] o,
                                        input logic [1:0] sz, input logic sg,
                                        input logic be);
    logic [7:0]  b, hi, lo;
    logic [15:0] h;
    if (sz == 2'b00) begin
      b = lane(d, int'(o));
      return {1'b0, (sg ? {{24{b[7]}}, b} : {24'h0, b})};
    end else if (sz == 2'b01) begin
      if (o[0]) return {1'b1, 32'h0};
      if (be) begin hi = lane(d, int'(o)); lo = lane(d, int'(o) + 1); end
      else    begin lo = lane(d, int'(o)); hi = lane(d, int'(o) + 1); end
      h = {hi, lo};
      return {1'b0, (sg ? {{16{h[15]}}, h} : {16'h0, h})};
    end else begin
      if (o != 2'b00) return {1'b1, 32'h0};
      if (be) return {1'b0, lane(d, 0), lane(d, 1), lane(d, 2), lane(d, 3)};
      return {1'b0, d};
    end
  endfunction

  task automatic check(input string tag, input logic v, input logic m,
                       input logic [31:0] dv, input logic ev, input logic em,
                       input logic [31:0] edv);
    checks++;
    if (v !== ev || m !== em || dv !== edv) begin
      errors++;
      $display("FAIL %s valid=%0b mis=%0b data=%h expected valid=%0b mis=%0b data=%h",
               tag, v, m, dv, ev, em, edv);
    end
  endtask

  // called at a negative edge; returns at the next negative edge
  task automatic load(input string tag, input logic [31:0] d, input logic [1:0] o,
                      input logic [1:0] sz, input logic sg, input logic be);
    logic [32:0] e;
    e = model(d, o, sz, sg, be);
    req_valid_i = 1'b1; mem_data_i = d; byte_ofs_i = o;
    size_i = sz; signed_i = sg; big_endian_i = be;
    @(negedge clk);
    req_valid_i = 1'b0;
    if (e[32]) begin
      check(tag, wr_valid_o, misalign_o, wr_data_o, 1'b0, 1'b1, last_good);
    end else begin
      check(tag, wr_valid_o, misalign_o, wr_data_o, 1'b1, 1'b0, e[31:0]);
      last_good = e[31:0];
    end
  endtask

  task automatic idle(input string tag);
    req_valid_i = 1'b0;
    @(negedge clk);
    check(tag, wr_valid_o, misalign_o, wr_data_o, 1'b0, 1'b0, last_good);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog run did not finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    rst_n = 1'b0; req_valid_i = 1'b0; mem_data_i = '0; byte_ofs_i = '0;
    size_i = '0; signed_i = 1'b0; big_endian_i = 1'b0;
    void'($urandom(32'd7531));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 reset", wr_valid_o, misalign_o, wr_data_o, 1'b0, 1'b0, 32'h0);

    // R2 / R3: byte in every lane, both modes
    for (int k = 0; k < 4; k++) begin
      load("R2 ubyte", 32'h80 << (8*k) | 32'h01010101 & ~(32'hFF << (8*k)),
           2'(k), 2'b00, 1'b0, k[0]);
      load("R3 sbyte", 32'h80 << (8*k), 2'(k), 2'b00, 1'b1, ~k[0]);
    end
    load("R3 sbyte pos", 32'h007F0000, 2'd2, 2'b00, 1'b1, 1'b1);

    // R4 / R5 halfwords
    load("R4 half be 0", 32'h11223344, 2'd0, 2'b01, 1'b0, 1'b1);
    load("R4 half le 0", 32'h11223344, 2'd0, 2'b01, 1'b0, 1'b0);
    load("R4 half be 2", 32'h11223344, 2'd2, 2'b01, 1'b0, 1'b1);
    load("R4 half le 2", 32'h11223344, 2'd2, 2'b01, 1'b0, 1'b0);
    load("R5 shalf le",  32'h00008001, 2'd0, 2'b01, 1'b1, 1'b0);
    load("R5 shalf be",  32'h00008001, 2'd0, 2'b01, 1'b1, 1'b1);
    load("R5 uhalf",     32'h80010000, 2'd2, 2'b01, 1'b0, 1'b0);

    // R6 words, including the 11 encoding
    load("R6 word be",   32'hA1B2C3D4, 2'd0, 2'b10, 1'b0, 1'b1);
    load("R6 word le",   32'hA1B2C3D4, 2'd0, 2'b10, 1'b1, 1'b0);
    load("R6 wide be",   32'h0F1E2D3C, 2'd0, 2'b11, 1'b0, 1'b1);

    // R7 misaligned accesses hold data, then recover
    load("R7 half odd1", 32'hDEADBEEF, 2'd1, 2'b01, 1'b1, 1'b0);
    load("R7 half odd3", 32'hDEADBEEF, 2'd3, 2'b01, 1'b0, 1'b1);
    for (int k = 1; k < 4; k++)
      load("R7 word ofs", 32'hCAFEF00D, 2'(k), 2'b10, 1'b0, k[0]);
    load("R7 recover", 32'h12345678, 2'd1, 2'b00, 1'b0, 1'b0);

    // R8 idle cycles
    idle("R8 idle");
    idle("R8 idle");

    // R9 mode toggling back to back on the same word
    load("R9 be", 32'h55AA66BB, 2'd0, 2'b10, 1'b0, 1'b1);
    load("R9 le", 32'h55AA66BB, 2'd0, 2'b10, 1'b0, 1'b0);
    load("R9 be", 32'h55AA66BB, 2'd2, 2'b01, 1'b1, 1'b1);

    // random mix
    for (int i = 0; i < 800; i++) begin
      logic [1:0] sz;
      rd = $urandom;
      sz = 2'($urandom_range(0, 3));
      load(sz == 2'b00 ? "R2 rnd" : (sz == 2'b01 ? "R4 rnd" : "R6 rnd"),
           rd, 2'($urandom_range(0, 3)), sz, 1'($urandom_range(0, 1)),
           1'($urandom_range(0, 1)));
      if ($urandom_range(0, 9) == 0) idle("R8 rnd idle");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule